// File: doc/BRIEF.md
# Asynchronous Queue List Walker with Parking

This block walks a circular linked list of bulk and control queue heads during the asynchronous part of each micro-frame. It fetches one element at a time over a request/acknowledge interface and looks at the element's attributes. For each element that holds work it issues a bus transaction command. It then follows the element's next pointer, so the elements are served in round-robin order.

A high-speed element may keep the walker for up to a programmed number of back-to-back transactions. This is called parking, and it can be switched on or off. The walker leaves a parked element early when a transaction ends short, is NAKed, or reports that the queue has no more work. Full/low-speed elements are never parked, and the command for them is flagged so that split protocol is used. The walker stops when it comes back to the marked head element after a whole pass in which nothing was issued. While the phase grant is low the walker holds its place, and it continues from the same element when the grant returns.

Software starts the walker from the stopped state by giving it a starting pointer. The walker reports its current pointer and whether it is stopped.

Top module: `async_list_walker`

## Requirements
- R1: After an element has been served, the next fetch uses that element's next pointer (el_next), so the list is visited in its linked order.
- R2: Unless parking applies, each element gets at most one transaction per visit. issue_valid is a single-cycle command and is never high in two consecutive cycles.
- R3: When park_en=1 and an element has el_hs=1, it gets up to park_max back-to-back transactions (issue commands with the same issue_ptr) before the walker advances. park_max=0 is treated as 1.
- R4: A parked element is released after the current transaction when xfer_short=1, xfer_nak=1 or xfer_more=0 is reported with xfer_done.
- R5: An element with el_hs=0 gets exactly one transaction per visit, whatever the park settings. Its command carries issue_split=1. A high-speed element's command carries issue_split=0.
- R6: An element with el_qh=0, el_active=0 or el_work=0 gets no transaction, and the walker fetches its el_next.
- R7: When an acknowledged element has el_head=1 and no transaction has completed since the previous head visit of the same run, the walker stops: idle=1, and fetch_req and issue_valid stay low.
- R8: While grant=0, fetch_req and issue_valid are low and the current pointer is held. Walking resumes from the same element when grant returns. A transaction already in flight may still complete.
- R9: When idle, a start pulse loads start_ptr and the first fetch uses it. A start pulse while running is ignored.
- R10: After reset the walker is idle, cur_ptr=0, and no fetch or issue is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| start_ptr | input | PTR_W | Element pointer to start the walk from |
| grant | input | 1 | Asynchronous phase grant |
| park_en | input | 1 | Enable parking on high-speed elements |
| park_max | input | PARK_W | Transactions per parked visit (0 means 1) |
| fetch_req | output | 1 | Request for the element at fetch_ptr |
| fetch_ptr | output | PTR_W | Pointer of the element being fetched |
| fetch_ack | input | 1 | Element attributes are valid |
| el_next | input | PTR_W | Next pointer of the fetched element |
| el_hs | input | 1 | 1 = high-speed element, 0 = full/low speed |
| el_active | input | 1 | Element is active |
| el_work | input | 1 | Element has work pending |
| el_qh | input | 1 | Element is a queue head (the only valid type) |
| el_head | input | 1 | Element is the marked list head |
| issue_valid | output | 1 | One-cycle transaction command |
| issue_ptr | output | PTR_W | Element the command is for |
| issue_split | output | 1 | Use split protocol (full/low-speed element) |
| xfer_done | input | 1 | Issued transaction has finished |
| xfer_short | input | 1 | Finished transaction returned a short packet |
| xfer_nak | input | 1 | Finished transaction was NAKed |
| xfer_more | input | 1 | Element still has work after this transaction |
| cur_ptr | output | PTR_W | Current element pointer |
| idle | output | 1 | Walker is stopped |

## Verification
The hardest state to reach is a stop that is correct: the walker has to come back to the marked head after a pass in which every element was skipped. That only happens once earlier passes have used up all the work, and it must not happen when the only work came from a parked element or arrived just before the head. The stimulus builds rings with a random stride and random head position. Each element gets a finite number of transfers, so work runs out over several passes. Random grant drops, early-release flags and ignored start pulses are mixed in, and a bench model tracks each expected fetch and issue cycle by cycle. Directed lists cover an empty ring, a full-length park with no early release, and a ring with only full/low-speed elements and parking on.

// File: rtl/alw_pkg.sv
package alw_pkg;
    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_FETCH = 2'd1,
        WK_ISSUE = 2'd2,
        WK_WAIT  = 2'd3
    } walk_state_e;
endpackage

// File: rtl/alw_park_ctr.sv
// Counts transactions spent on the current element and decides whether to stay.
module alw_park_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bump,
    input  logic             park_en,
    input  logic [CNT_W-1:0] park_max,
    input  logic             is_hs,
    input  logic             rel_short,
    input  logic             rel_nak,
    input  logic             more,
    output logic             stay,
    output logic [CNT_W-1:0] cnt
);
    localparam int LIM_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pk_t;

    pk_t              r_q, r_d;
    logic [LIM_W-1:0] lim_d, used_d;

    always_comb begin
        lim_d  = (park_en && is_hs && park_max != '0) ? {1'b0, park_max} : LIM_W'(1);
        used_d = {1'b0, r_q.cnt} + LIM_W'(1);
        stay   = (used_d < lim_d) && !rel_short && !rel_nak && more;
        r_d    = r_q;
        if (clr)
            r_d.cnt = '0;
        else if (bump)
            r_d.cnt = stay ? used_d[CNT_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cnt = r_q.cnt;

    // R4
    early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && (!more || rel_short || rel_nak)) |=> (r_q.cnt == '0));

    // R5
    no_park_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !is_hs) |=> (r_q.cnt == '0));
endmodule

// File: rtl/alw_pass_track.sv
// Remembers whether the head was seen and whether any transaction finished since.
module alw_pass_track (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic head_visit,
    input  logic served,
    output logic empty_hit
);
    typedef struct packed {
        logic seen;
        logic work;
    } ps_t;

    ps_t r_q, r_d;

    always_comb begin
        empty_hit = head_visit && r_q.seen && !r_q.work;
        r_d       = r_q;
        if (restart) begin
            r_d = '0;
        end else begin
            if (head_visit) begin
                r_d.seen = 1'b1;
                r_d.work = 1'b0;
            end
            if (served)
                r_d.work = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R7
    first_head_no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !empty_hit);
endmodule

// File: rtl/async_list_walker.sv
module async_list_walker
    import alw_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int PARK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PTR_W-1:0]  start_ptr,
    input  logic              grant,
    input  logic              park_en,
    input  logic [PARK_W-1:0] park_max,
    output logic              fetch_req,
    output logic [PTR_W-1:0]  fetch_ptr,
    input  logic              fetch_ack,
    input  logic [PTR_W-1:0]  el_next,
    input  logic              el_hs,
    input  logic              el_active,
    input  logic              el_work,
    input  logic              el_qh,
    input  logic              el_head,
    output logic              issue_valid,
    output logic [PTR_W-1:0]  issue_ptr,
    output logic              issue_split,
    input  logic              xfer_done,
    input  logic              xfer_short,
    input  logic              xfer_nak,
    input  logic              xfer_more,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic              idle
);
    typedef struct packed {
        walk_state_e      st;
        logic [PTR_W-1:0] cur;
        logic [PTR_W-1:0] nxt;
        logic             hs;
    } regs_t;

    regs_t             r_q, r_d;
    logic              park_clr, park_bump, park_stay;
    logic [PARK_W-1:0] park_cnt;
    logic              head_visit, pass_restart, empty_hit;

    alw_park_ctr #(.CNT_W(PARK_W)) u_park (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (park_clr),
        .bump      (park_bump),
        .park_en   (park_en),
        .park_max  (park_max),
        .is_hs     (r_q.hs),
        .rel_short (xfer_short),
        .rel_nak   (xfer_nak),
        .more      (xfer_more),
        .stay      (park_stay),
        .cnt       (park_cnt)
    );

    alw_pass_track u_pass (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (pass_restart),
        .head_visit (head_visit),
        .served     (park_bump),
        .empty_hit  (empty_hit)
    );

    always_comb begin
        r_d          = r_q;
        park_clr     = 1'b0;
        park_bump    = 1'b0;
        head_visit   = 1'b0;
        pass_restart = 1'b0;
        unique case (r_q.st)
            WK_IDLE: begin
                if (start) begin
                    r_d.cur      = start_ptr;
                    r_d.st       = WK_FETCH;
                    pass_restart = 1'b1;
                    park_clr     = 1'b1;
                end
            end
            WK_FETCH: begin
                if (grant && fetch_ack) begin
                    head_visit = el_head;
                    if (el_head && empty_hit) begin
                        r_d.st = WK_IDLE;
                    end else if (el_qh && el_active && el_work) begin
                        r_d.st   = WK_ISSUE;
                        r_d.nxt  = el_next;
                        r_d.hs   = el_hs;
                        park_clr = 1'b1;
                    end else begin
                        r_d.cur = el_next;
                    end
                end
            end
            WK_ISSUE: begin
                if (grant)
                    r_d.st = WK_WAIT;
            end
            WK_WAIT: begin
                if (xfer_done) begin
                    park_bump = 1'b1;
                    if (park_stay) begin
                        r_d.st = WK_ISSUE;
                    end else begin
                        r_d.cur = r_q.nxt;
                        r_d.st  = WK_FETCH;
                    end
                end
            end
            default: r_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fetch_req   = (r_q.st == WK_FETCH) && grant;
    assign fetch_ptr   = r_q.cur;
    assign issue_valid = (r_q.st == WK_ISSUE) && grant;
    assign issue_ptr   = r_q.cur;
    assign issue_split = !r_q.hs;
    assign cur_ptr     = r_q.cur;
    assign idle        = (r_q.st == WK_IDLE);

    // R8
    hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant && r_q.st != WK_WAIT && r_q.st != WK_IDLE) |=> $stable(r_q.cur));

    // R2
    single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !issue_valid);

    // R5
    fs_no_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_split) |-> (park_cnt == '0));

    // R7
    stop_at_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(fetch_ack && el_head));

    // R9
    stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start) |=> idle);
endmodule

// File: tb/async_list_walker_test.sv
`timescale 1ns/1ps
module async_list_walker_test;
    localparam int PW = 8;
    localparam int N  = 8;
    localparam int E_IDLE = 0, E_FETCH = 1, E_ISSUE = 2, E_WAIT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          start = 1'b0;
    logic [PW-1:0] start_ptr = '0;
    logic          grant = 1'b0, park_en = 1'b0;
    logic [1:0]    park_max = 2'd0;
    logic          fetch_req, fetch_ack = 1'b0;
    logic [PW-1:0] fetch_ptr, el_next = '0;
    logic          el_hs = 1'b0, el_active = 1'b0, el_work = 1'b0, el_qh = 1'b0, el_head = 1'b0;
    logic          issue_valid, issue_split;
    logic [PW-1:0] issue_ptr, cur_ptr;
    logic          xfer_done = 1'b0, xfer_short = 1'b0, xfer_nak = 1'b0, xfer_more = 1'b0;
    logic          idle;

    async_list_walker #(.PTR_W(PW), .PARK_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr), .grant(grant),
        .park_en(park_en), .park_max(park_max), .fetch_req(fetch_req), .fetch_ptr(fetch_ptr),
        .fetch_ack(fetch_ack), .el_next(el_next), .el_hs(el_hs), .el_active(el_active),
        .el_work(el_work), .el_qh(el_qh), .el_head(el_head), .issue_valid(issue_valid),
        .issue_ptr(issue_ptr), .issue_split(issue_split), .xfer_done(xfer_done),
        .xfer_short(xfer_short), .xfer_nak(xfer_nak), .xfer_more(xfer_more),
        .cur_ptr(cur_ptr), .idle(idle)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int m_next[N];
    bit m_hs[N], m_act[N], m_qh[N];
    int m_rem[N];
    int m_head;
    int exp_kind = E_IDLE, exp_ptr = 0, m_cnt = 0, lat = 0, grant_low = 0;
    bit m_seen = 0, m_work = 0, g_cur = 0, no_early = 0, start_prev = 0;
    string why = "R1";

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    function automatic int park_limit(bit hs);
        if (park_en && hs && park_max != 2'd0) return int'(park_max);
        return 1;
    endfunction

    task automatic build(int stride, int head, int hs_pct, int rem_max, bit all_ok);
        for (int i = 0; i < N; i++) begin
            m_next[i] = (i + stride) % N;
            m_hs[i]   = ($urandom % 100) < hs_pct;
            m_act[i]  = all_ok || ($urandom % 5 != 0);
            m_qh[i]   = all_ok || ($urandom % 6 != 0);
            m_rem[i]  = $urandom % (rem_max + 1);
        end
        m_head = head;
    endtask

    task automatic step(output bit finished);
        bit g_next, sh, nk, mo;
        int e, lim;
        string tag;
        finished = 0;
        @(negedge clk);
        tag = start_prev ? "R9" : why;
        chk(idle == (exp_kind == E_IDLE), (exp_kind == E_IDLE) ? "R7" : tag, "idle", idle, exp_kind == E_IDLE);
        case (exp_kind)
            E_IDLE: begin
                chk(!fetch_req && !issue_valid, "R7", "quiet when stopped", fetch_req | issue_valid, 0);
                finished = 1;
            end
            E_FETCH: begin
                chk(fetch_req == g_cur, "R8", "fetch_req follows grant", fetch_req, g_cur);
                chk(fetch_ptr == exp_ptr, tag, "fetch_ptr", fetch_ptr, exp_ptr);
                chk(!issue_valid, tag, "no issue while fetching", issue_valid, 0);
            end
            E_ISSUE: begin
                chk(issue_valid == g_cur, "R8", "issue_valid follows grant", issue_valid, g_cur);
                if (g_cur) begin
                    chk(issue_ptr == exp_ptr, tag, "issue_ptr", issue_ptr, exp_ptr);
                    chk(issue_split == !m_hs[exp_ptr], "R5", "issue_split", issue_split, !m_hs[exp_ptr]);
                end
            end
            default: begin
                chk(!fetch_req && !issue_valid, "R2", "quiet while waiting", fetch_req | issue_valid, 0);
            end
        endcase
        fetch_ack = 0; xfer_done = 0; xfer_short = 0; xfer_nak = 0; xfer_more = 0;
        start = 0; start_prev = 0;
        el_next = '0; el_hs = 0; el_active = 0; el_work = 0; el_qh = 0; el_head = 0;
        if (finished) return;
        g_next = ($urandom % 100) >= grant_low;
        if ($urandom % 20 == 0) begin
            start = 1; start_ptr = PW'($urandom % N); start_prev = 1;  // R9: ignored while running
        end
        case (exp_kind)
            E_FETCH: if (g_next && ($urandom % 3 != 0)) begin
                e = exp_ptr;
                fetch_ack = 1;
                el_next = PW'(m_next[e]); el_hs = m_hs[e]; el_active = m_act[e];
                el_work = m_rem[e] > 0; el_qh = m_qh[e]; el_head = (e == m_head);
                if (e == m_head && m_seen && !m_work) begin
                    exp_kind = E_IDLE;
                end else begin
                    if (e == m_head) begin m_seen = 1; m_work = 0; end
                    if (m_qh[e] && m_act[e] && m_rem[e] > 0) begin
                        exp_kind = E_ISSUE; m_cnt = 0; why = m_hs[e] ? "R2" : "R5";
                    end else begin
                        exp_ptr = m_next[e]; why = "R6";
                    end
                end
            end
            E_ISSUE: if (g_next) begin
                exp_kind = E_WAIT; lat = $urandom % 3;
            end
            E_WAIT: if (lat == 0) begin
                e  = exp_ptr;
                sh = !no_early && ($urandom % 6 == 0);
                nk = !no_early && ($urandom % 6 == 0);
                mo = m_rem[e] > 1;
                m_rem[e]--;
                xfer_done = 1; xfer_short = sh; xfer_nak = nk; xfer_more = mo;
                m_work = 1;
                lim = park_limit(m_hs[e]);
                if (m_cnt + 1 < lim && !sh && !nk && mo) begin
                    m_cnt++; exp_kind = E_ISSUE; why = "R3";
                end else begin
                    if (m_cnt + 1 < lim) why = "R4";
                    else why = m_hs[e] ? "R1" : "R5";
                    m_cnt = 0; exp_ptr = m_next[e]; exp_kind = E_FETCH;
                end
            end else lat--;
            default: ;
        endcase
        grant = g_next; g_cur = g_next;
    endtask

    task automatic run_list(int sp, int glow, int maxc);
        bit fin;
        int k;
        @(negedge clk);
        chk(idle == 1, "R9", "idle before start", idle, 1);
        start = 1; start_ptr = PW'(sp); grant = 1; g_cur = 1;
        exp_kind = E_FETCH; exp_ptr = sp; m_seen = 0; m_work = 0; m_cnt = 0;
        why = "R9"; grant_low = glow;
        fin = 0; k = 0;
        while (!fin && k < maxc) begin step(fin); k++; end
        chk(fin, "R7", "stopped within budget", fin, 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(idle == 1, "R10", "idle in reset", idle, 1);
        chk(!fetch_req && !issue_valid, "R10", "no requests in reset", fetch_req | issue_valid, 0);
        rst_n = 1;
        @(negedge clk);
        chk(idle == 1, "R10", "idle after reset", idle, 1);
        chk(cur_ptr == 0, "R10", "cur_ptr after reset", cur_ptr, 0);

        // R7: empty ring stops after one full pass
        park_en = 0; park_max = 2'd1; no_early = 0;
        build(1, 3, 50, 0, 1'b1);
        run_list(3, 0, 500);

        // R3: full-length park on high-speed elements, no early release
        park_en = 1; park_max = 2'd3; no_early = 1;
        build(3, 0, 100, 5, 1'b1);
        run_list(5, 10, 3000);

        // R5: full/low-speed only, parking enabled but not applied
        park_en = 1; park_max = 2'd3; no_early = 1;
        build(5, 2, 0, 3, 1'b1);
        run_list(2, 10, 3000);

        // R3: park_max of zero acts as one
        park_en = 1; park_max = 2'd0; no_early = 1;
        build(1, 4, 100, 3, 1'b1);
        run_list(4, 0, 3000);

        // Random rings: skips (R6), early release (R4), grant drops (R8)
        no_early = 0;
        for (int t = 0; t < 12; t++) begin
            park_en  = ($urandom % 4) != 0;
            park_max = 2'($urandom % 4);
            build(2 * int'($urandom % 4) + 1, int'($urandom % N), 60, 4, 1'b0);
            run_list(int'($urandom % N), 5 + int'($urandom % 30), 5000);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule